// File: doc/BRIEF.md
# Paged-Address I2C Register Target

This block is an I2C target that opens a 16-bit register space to an external bus master. It watches the SCL and SDA lines, which arrive already synchronised to the system clock, and pulls SDA low through an open-drain enable. It recognises start, repeated start and stop conditions. It matches its fixed 7-bit device address, acknowledges the bytes meant for it and keeps an internal register pointer. The pointer steps forward after every byte written or read, so bursts cover consecutive locations.

A static configuration input selects between two addressing forms. In the short form the master sends one offset byte, and the upper address byte comes from a small page register inside the block. In the long form the master sends a 16-bit offset, high byte first, and that offset is used directly. The page register is always reachable through a window at the very top of the offset space, so it can be loaded in either form. To read, the master first writes the offset with no data and no stop. It then issues a repeated start with the read bit set, and the target returns bytes from the pointer until the master answers with a NACK. Towards the chip the block drives a plain register-bank port: an address, write data, a single-cycle write strobe, and read data that must follow the address combinationally.

Top module: `i2c_pg_slave`

## Requirements
- R1: The target answers only the 7-bit address 0x5B (address byte 0xB6 for write, 0xB7 for read, R/W in bit 0). Any other address byte gets no ACK, and the bytes that follow are ignored until the next start: no ACK and no write strobe.
- R2: A start or repeated start begins a fresh address phase at any point, and the pointer is kept. A stop returns the target to idle with SDA released.
- R3: With `wide_offset` low, one offset byte follows the write address. The bank address is {page byte 1, offset byte}.
- R4: With `wide_offset` high, two offset bytes follow the write address, high byte first. The bank address is the 16-bit offset itself, and the page register is not applied.
- R5: The page register has four bytes, all reset to zero. It sits at offsets 0xFC to 0xFF in short mode and 0xFFFC to 0xFFFF in long mode, with byte index equal to the low two offset bits. Byte 1 supplies the upper address byte in short mode, and a value loaded in either mode holds in both.
- R6: Data bytes that land in the page window update the page register and produce no bank write strobe.
- R7: The target ACKs its address and every written byte. Each data byte outside the page window produces exactly one single-cycle `reg_we` pulse, carrying the byte and the address of the current pointer, while SCL is low.
- R8: The pointer advances by one after every data byte written or read. In short mode only the 8-bit offset wraps (0xFF to 0x00) and the page is unchanged.
- R9: After a repeated start with the read bit, the target sends bytes MSB first from the pointer set by the last write phase, or left by an earlier read. A master ACK continues the read with the next location.
- R10: A master NACK ends the read: the target releases SDA and drives nothing until the next start.
- R11: Reads from the page window return the stored page bytes and not bank data.
- R12: The target changes its SDA drive only while SCL is low. It never starts driving in a cycle that follows SCL high.
- R13: After reset `sda_oe` and `reg_we` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wide_offset | input | 1 | Static select: 0 for a one-byte offset, 1 for a two-byte offset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level (the resolved bus) |
| sda_oe | output | 1 | High pulls SDA low |
| reg_addr | output | 16 | Register-bank address |
| reg_wdata | output | 8 | Register-bank write data |
| reg_we | output | 1 | Single-cycle register-bank write strobe |
| reg_rdata | input | 8 | Register-bank read data, combinational from `reg_addr` |

## Verification
The hardest case to reach is a pointer that crosses the page window. A short-mode burst that starts just below 0xFC has to switch from bank strobes to page updates in the middle of the transfer. A burst that starts at 0xFF has to wrap to offset 0x00 while keeping the page it has just loaded. Directed bursts placed at offsets 0xFB and 0xFF produce both crossings. A page byte loaded through the long-mode window is then used as the upper address in short mode. Random bursts from a fixed seed, in both modes and in both directions, check the effective addresses against a bench model of the page and pointer.

// File: rtl/i2c_pg_pkg.sv
package i2c_pg_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_RX_ACK,
      ST_TX,
      ST_TX_ACK
   } i2c_st_e;

   typedef enum logic [1:0] {
      K_ADDR,
      K_OFFH,
      K_OFFL,
      K_DATA
   } byte_kind_e;

   typedef struct packed {
      logic start;
      logic stop;
      logic rise;
      logic fall;
      logic sda;
   } bus_ev_t;

endpackage

// File: rtl/i2c_pg_line_mon.sv
module i2c_pg_line_mon
   import i2c_pg_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    scl_i,
   input  logic    sda_i,
   output bus_ev_t ev
);

   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   always_comb begin
      ev.start = scl_i & scl_q & sda_q & ~sda_i;
      ev.stop  = scl_i & scl_q & ~sda_q & sda_i;
      ev.rise  = scl_i & ~scl_q;
      ev.fall  = ~scl_i & scl_q;
      ev.sda   = sda_i;
   end

endmodule

// File: rtl/i2c_pg_page_file.sv
module i2c_pg_page_file #(
   parameter int ADDR_W     = 16,
   parameter int PAGE_BYTES = 4,
   parameter int PAGE_SEL   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wide,
   input  logic [ADDR_W-1:0] ptr,
   input  logic              wr_en,
   input  logic [7:0]        wdata,
   output logic [ADDR_W-1:0] eff_addr,
   output logic              in_win,
   output logic [7:0]        rd_byte
);

   localparam int IDX_W = $clog2(PAGE_BYTES);
   localparam int HI_W  = ADDR_W - 8;

   logic [PAGE_BYTES*8-1:0] pg_flat;
   logic [IDX_W-1:0]        idx;
   logic                    win_short;
   logic                    win_long;

   assign idx       = ptr[IDX_W-1:0];
   assign win_short = &ptr[7:IDX_W];
   assign win_long  = &ptr[ADDR_W-1:IDX_W];
   assign in_win    = wide ? win_long : win_short;

   for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_pg
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= 8'h00;
         else if (wr_en && (idx == IDX_W'(g)))
            q <= wdata;
      end
      assign pg_flat[g*8 +: 8] = q;
   end

   assign rd_byte = pg_flat[idx*8 +: 8];

   if (HI_W == 8) begin : g_hi_byte
      assign eff_addr = wide ? ptr : {pg_flat[PAGE_SEL*8 +: 8], ptr[7:0]};
   end else begin : g_hi_trunc
      assign eff_addr = wide ? ptr : {pg_flat[PAGE_SEL*8 +: HI_W], ptr[7:0]};
   end

endmodule

// File: rtl/i2c_pg_ctrl.sv
module i2c_pg_ctrl
   import i2c_pg_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h5B,
   parameter int         ADDR_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bus_ev_t           ev,
   input  logic              wide,
   input  logic [7:0]        rd_src,
   input  logic              in_win,
   output logic [ADDR_W-1:0] ptr,
   output logic              sda_oe,
   output logic              bank_we,
   output logic              page_we,
   output logic [7:0]        wdata
);

   i2c_st_e           st;
   byte_kind_e        kind;
   logic [3:0]        cnt;
   logic [7:0]        sh;
   logic              rw;
   logic              mack;
   logic              inc_pend;
   logic [ADDR_W-1:0] ptr_q;
   logic [ADDR_W-1:0] ptr_inc;

   assign ptr = ptr_q;

   always_comb begin
      if (wide)
         ptr_inc = ptr_q + ADDR_W'(1);
      else
         ptr_inc = {ptr_q[ADDR_W-1:8], ptr_q[7:0] + 8'd1};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         kind     <= K_ADDR;
         cnt      <= 4'd0;
         sh       <= 8'h00;
         rw       <= 1'b0;
         mack     <= 1'b0;
         inc_pend <= 1'b0;
         ptr_q    <= '0;
         sda_oe   <= 1'b0;
         bank_we  <= 1'b0;
         page_we  <= 1'b0;
         wdata    <= 8'h00;
      end else begin
         bank_we <= 1'b0;
         page_we <= 1'b0;
         if (ev.start) begin
            st     <= ST_RX;
            kind   <= K_ADDR;
            cnt    <= 4'd0;
            sda_oe <= 1'b0;
         end else if (ev.stop) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (st)
               ST_RX: begin
                  if (ev.rise && cnt < 4'd8) begin
                     sh  <= {sh[6:0], ev.sda};
                     cnt <= cnt + 4'd1;
                  end else if (ev.fall && cnt == 4'd8) begin
                     case (kind)
                        K_ADDR: begin
                           if (sh[7:1] == DEV_ADDR) begin
                              rw     <= sh[0];
                              sda_oe <= 1'b1;
                              st     <= ST_RX_ACK;
                           end else begin
                              st <= ST_IDLE;
                           end
                        end
                        K_OFFH: begin
                           ptr_q[ADDR_W-1:8] <= sh[ADDR_W-9:0];
                           kind              <= K_OFFL;
                           sda_oe            <= 1'b1;
                           st                <= ST_RX_ACK;
                        end
                        K_OFFL: begin
                           ptr_q[7:0] <= sh;
                           kind       <= K_DATA;
                           sda_oe     <= 1'b1;
                           st         <= ST_RX_ACK;
                        end
                        default: begin
                           wdata    <= sh;
                           bank_we  <= ~in_win;
                           page_we  <= in_win;
                           inc_pend <= 1'b1;
                           sda_oe   <= 1'b1;
                           st       <= ST_RX_ACK;
                        end
                     endcase
                  end
               end
               ST_RX_ACK: begin
                  if (ev.fall) begin
                     cnt <= 4'd0;
                     if (inc_pend) begin
                        ptr_q    <= ptr_inc;
                        inc_pend <= 1'b0;
                     end
                     if (kind == K_ADDR && rw) begin
                        sh     <= rd_src;
                        sda_oe <= ~rd_src[7];
                        st     <= ST_TX;
                     end else begin
                        sda_oe <= 1'b0;
                        st     <= ST_RX;
                        if (kind == K_ADDR)
                           kind <= wide ? K_OFFH : K_OFFL;
                     end
                  end
               end
               ST_TX: begin
                  if (ev.fall) begin
                     if (cnt == 4'd7) begin
                        sda_oe <= 1'b0;
                        ptr_q  <= ptr_inc;
                        st     <= ST_TX_ACK;
                     end else begin
                        sh     <= {sh[6:0], 1'b0};
                        sda_oe <= ~sh[6];
                        cnt    <= cnt + 4'd1;
                     end
                  end
               end
               ST_TX_ACK: begin
                  if (ev.rise) begin
                     mack <= ~ev.sda;
                  end else if (ev.fall) begin
                     cnt <= 4'd0;
                     if (mack) begin
                        sh     <= rd_src;
                        sda_oe <= ~rd_src[7];
                        st     <= ST_TX;
                     end else begin
                        sda_oe <= 1'b0;
                        st     <= ST_IDLE;
                     end
                  end
               end
               default: begin
                  sda_oe <= 1'b0;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/i2c_pg_slave.sv
module i2c_pg_slave
   import i2c_pg_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR   = 7'h5B,
   parameter int         ADDR_W     = 16,
   parameter int         PAGE_BYTES = 4,
   parameter int         PAGE_SEL   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wide_offset,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [7:0]        reg_wdata,
   output logic              reg_we,
   input  logic [7:0]        reg_rdata
);

   if (ADDR_W != 16) begin : g_chk_aw
      $error("i2c_pg_slave: ADDR_W must be 16");
   end
   if (PAGE_BYTES < 2 || PAGE_BYTES > 8 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_chk_pb
      $error("i2c_pg_slave: PAGE_BYTES must be a power of two in 2..8");
   end
   if (PAGE_SEL < 0 || PAGE_SEL >= PAGE_BYTES) begin : g_chk_ps
      $error("i2c_pg_slave: PAGE_SEL out of range");
   end

   bus_ev_t           ev;
   logic [ADDR_W-1:0] ptr;
   logic              in_win;
   logic [7:0]        page_rd;
   logic [7:0]        rd_src;
   logic              page_we;

   i2c_pg_line_mon u_mon (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_i (scl_i),
      .sda_i (sda_i),
      .ev    (ev)
   );

   i2c_pg_page_file #(
      .ADDR_W     (ADDR_W),
      .PAGE_BYTES (PAGE_BYTES),
      .PAGE_SEL   (PAGE_SEL)
   ) u_page (
      .clk      (clk),
      .rst_n    (rst_n),
      .wide     (wide_offset),
      .ptr      (ptr),
      .wr_en    (page_we),
      .wdata    (reg_wdata),
      .eff_addr (reg_addr),
      .in_win   (in_win),
      .rd_byte  (page_rd)
   );

   assign rd_src = in_win ? page_rd : reg_rdata;

   i2c_pg_ctrl #(
      .DEV_ADDR (DEV_ADDR),
      .ADDR_W   (ADDR_W)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev      (ev),
      .wide    (wide_offset),
      .rd_src  (rd_src),
      .in_win  (in_win),
      .ptr     (ptr),
      .sda_oe  (sda_oe),
      .bank_we (reg_we),
      .page_we (page_we),
      .wdata   (reg_wdata)
   );

endmodule

// File: rtl/i2c_pg_slave_chk.sv
module i2c_pg_slave_chk #(
   parameter int ADDR_W     = 16,
   parameter int PAGE_BYTES = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wide_offset,
   input logic              scl_i,
   input logic              sda_i,
   input logic              sda_oe,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_we
);

   localparam int IDX_W = $clog2(PAGE_BYTES);

   // R7: write strobe lasts a single cycle
   a_r7_we_single: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   // R7: strobe lands while SCL is low
   a_r7_we_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> !scl_i);

   // R6: no bank strobe inside the page window
   a_r6_no_we_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> (wide_offset ? !(&reg_addr[ADDR_W-1:IDX_W]) : !(&reg_addr[7:IDX_W])));

   // R12: drive starts only after SCL was low
   a_r12_oe_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !$past(scl_i));

   // R12: drive held steady through SCL high
   a_r12_oe_stable_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_i && $past(scl_i)) |-> $stable(sda_oe));

   // R2: a stop leaves SDA released
   a_r2_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> !sda_oe);

endmodule

bind i2c_pg_slave i2c_pg_slave_chk #(
   .ADDR_W     (ADDR_W),
   .PAGE_BYTES (PAGE_BYTES)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .wide_offset (wide_offset),
   .scl_i       (scl_i),
   .sda_i       (sda_i),
   .sda_oe      (sda_oe),
   .reg_addr    (reg_addr),
   .reg_we      (reg_we)
);

// File: tb/i2c_pg_slave_tb.sv
module i2c_pg_slave_tb_top;

   localparam int QP = 5;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wide;
   logic        scl;
   logic        msda;
   wire         sda_line;
   logic        sda_oe;
   logic [15:0] reg_addr;
   logic [7:0]  reg_wdata;
   logic        reg_we;
   logic [7:0]  reg_rdata;

   int n_chk = 0;
   int n_fail = 0;
   int wr_n = 0;
   int oe_hi_chg = 0;
   logic [15:0] la [0:63];
   logic [7:0]  ld [0:63];
   logic [7:0]  dbuf [0:7];
   logic [7:0]  rbuf [0:7];
   logic [7:0]  pg1;
   logic        prev_scl = 1'b1;
   logic        prev_oe = 1'b0;

   always #2 clk = ~clk;

   assign sda_line  = msda & ~sda_oe;

   function automatic logic [7:0] rdf(input logic [15:0] a);
      return a[7:0] ^ {a[14:8], a[15]} ^ 8'h3C;
   endfunction

   function automatic logic [15:0] exp_addr(input logic wm, input logic [7:0] p1, input logic [15:0] off);
      return wm ? off : {p1, off[7:0]};
   endfunction

   assign reg_rdata = rdf(reg_addr);

   i2c_pg_slave dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .wide_offset (wide),
      .scl_i       (scl),
      .sda_i       (sda_line),
      .sda_oe      (sda_oe),
      .reg_addr    (reg_addr),
      .reg_wdata   (reg_wdata),
      .reg_we      (reg_we),
      .reg_rdata   (reg_rdata)
   );

   always @(negedge clk) begin
      if (rst_n && reg_we) begin
         la[wr_n % 64] <= reg_addr;
         ld[wr_n % 64] <= reg_wdata;
         wr_n <= wr_n + 1;
      end
      if (rst_n && scl && prev_scl && (sda_oe != prev_oe))
         oe_hi_chg <= oe_hi_chg + 1;
      prev_scl <= scl;
      prev_oe  <= sda_oe;
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic qwait();
      repeat (QP) @(negedge clk);
   endtask

   task automatic b_start();
      msda = 1'b1; qwait();
      scl = 1'b1;  qwait();
      msda = 1'b0; qwait();
      scl = 1'b0;  qwait();
   endtask

   task automatic b_stop();
      msda = 1'b0; qwait();
      scl = 1'b1;  qwait();
      msda = 1'b1; qwait();
   endtask

   task automatic b_wbit(input logic b);
      msda = b;   qwait();
      scl = 1'b1; qwait(); qwait();
      scl = 1'b0; qwait();
   endtask

   task automatic b_rbit(output logic b);
      msda = 1'b1; qwait();
      scl = 1'b1;  qwait();
      b = sda_line; qwait();
      scl = 1'b0;  qwait();
   endtask

   task automatic tx_byte(input logic [7:0] v, output logic acked);
      logic a;
      for (int i = 7; i >= 0; i--) b_wbit(v[i]);
      b_rbit(a);
      acked = ~a;
   endtask

   task automatic rx_byte(input logic last, output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         b_rbit(b);
         v[i] = b;
      end
      b_wbit(last);
   endtask

   task automatic send_ptr(input logic wm, input logic [15:0] off, output int nacks);
      logic a;
      nacks = 0;
      b_start();
      tx_byte(8'hB6, a); if (!a) nacks++;
      if (wm) begin
         tx_byte(off[15:8], a); if (!a) nacks++;
      end
      tx_byte(off[7:0], a); if (!a) nacks++;
   endtask

   task automatic wr_burst(input logic wm, input logic [15:0] off, input int n, output int nacks);
      logic a;
      send_ptr(wm, off, nacks);
      for (int i = 0; i < n; i++) begin
         tx_byte(dbuf[i], a); if (!a) nacks++;
      end
      b_stop();
   endtask

   task automatic rd_burst(input int n, output int nacks);
      logic a;
      nacks = 0;
      b_start();
      tx_byte(8'hB7, a); if (!a) nacks++;
      for (int i = 0; i < n; i++) rx_byte(i == n - 1, rbuf[i]);
   endtask

   initial begin
      repeat (190000) @(negedge clk);
      n_fail++;
      $display("FAIL watchdog: actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
      $finish;
   end

   initial begin
      int nk;
      int base;
      logic b;
      logic a;
      void'($urandom(32'd20240611));
      rst_n = 1'b0; wide = 1'b0; scl = 1'b1; msda = 1'b1;
      repeat (10) @(negedge clk);
      chk("R13 sda_oe in reset", int'(sda_oe), 0);
      chk("R13 reg_we in reset", int'(reg_we), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R13 sda_oe after reset", int'(sda_oe), 0);

      // R5: page starts at zero
      base = wr_n; dbuf[0] = 8'h77;
      wr_burst(1'b0, 16'h0010, 1, nk);
      chk("R1 R7 acks on short write", nk, 0);
      chk("R7 strobe count", wr_n - base, 1);
      chk("R5 R3 reset page address", int'(la[base % 64]), 16'h0010);
      chk("R7 write data", int'(ld[base % 64]), 8'h77);

      // R1: foreign address ignored
      base = wr_n;
      b_start();
      tx_byte(8'hB8, a); chk("R1 foreign address no ack", int'(a), 0);
      tx_byte(8'h10, a); chk("R1 following byte no ack", int'(a), 0);
      tx_byte(8'h55, a); chk("R1 data byte no ack", int'(a), 0);
      b_stop();
      chk("R1 no strobe after foreign address", wr_n - base, 0);

      // R6: page load in short mode
      base = wr_n;
      dbuf[0] = 8'h00; dbuf[1] = 8'hC0; dbuf[2] = 8'h10; dbuf[3] = 8'h20;
      wr_burst(1'b0, 16'h00FC, 4, nk);
      chk("R6 page load acks", nk, 0);
      chk("R6 page load gives no strobe", wr_n - base, 0);
      pg1 = 8'hC0;

      // R3
      base = wr_n; dbuf[0] = 8'h50;
      wr_burst(1'b0, 16'h0024, 1, nk);
      chk("R3 paged address", int'(la[base % 64]), 16'hC024);
      chk("R3 paged data", int'(ld[base % 64]), 8'h50);

      // R8: burst
      base = wr_n; dbuf[0] = 8'h01; dbuf[1] = 8'h02; dbuf[2] = 8'h03;
      wr_burst(1'b0, 16'h0030, 3, nk);
      chk("R8 burst count", wr_n - base, 3);
      for (int i = 0; i < 3; i++) chk("R8 burst address", int'(la[(base + i) % 64]), 16'hC030 + i);

      // R8/R6: crossing into window
      base = wr_n; dbuf[0] = 8'hA1; dbuf[1] = 8'hB2;
      wr_burst(1'b0, 16'h00FB, 2, nk);
      chk("R6 crossing count", wr_n - base, 1);
      chk("R8 crossing first address", int'(la[base % 64]), 16'hC0FB);

      // R8: wrap from 0xFF to 0x00
      base = wr_n; dbuf[0] = 8'h3E; dbuf[1] = 8'h9D;
      wr_burst(1'b0, 16'h00FF, 2, nk);
      chk("R8 wrap count", wr_n - base, 1);
      chk("R8 wrap address keeps page", int'(la[base % 64]), 16'hC000);
      chk("R8 wrap data", int'(ld[base % 64]), 8'h9D);

      // R9/R10: read
      send_ptr(1'b0, 16'h0024, nk);
      rd_burst(3, nk);
      chk("R9 read address ack", nk, 0);
      for (int i = 0; i < 3; i++) chk("R9 read data", int'(rbuf[i]), int'(rdf(16'hC024 + i)));
      b_rbit(b);
      chk("R10 released after NACK", int'(b), 1);
      b_stop();

      // R11: page readback
      send_ptr(1'b0, 16'h00FD, nk);
      rd_burst(1, nk);
      b_stop();
      chk("R11 page byte 1 readback", int'(rbuf[0]), 8'hC0);
      rd_burst(1, nk);
      b_stop();
      chk("R9 R11 read continues at pointer", int'(rbuf[0]), 8'h10);

      // R4: long mode
      wide = 1'b1;
      base = wr_n; dbuf[0] = 8'h50;
      wr_burst(1'b1, 16'hCBE4, 1, nk);
      chk("R4 long mode acks", nk, 0);
      chk("R4 long mode address", int'(la[base % 64]), 16'hCBE4);

      // R5/R6: page through long window
      base = wr_n; dbuf[0] = 8'h7E; dbuf[1] = 8'h10; dbuf[2] = 8'h20;
      wr_burst(1'b1, 16'hFFFD, 3, nk);
      chk("R6 long window no strobe", wr_n - base, 0);
      send_ptr(1'b1, 16'hFFFD, nk);
      rd_burst(1, nk);
      b_stop();
      chk("R11 long window readback", int'(rbuf[0]), 8'h7E);
      pg1 = 8'h7E;

      wide = 1'b0;
      base = wr_n; dbuf[0] = 8'h11;
      wr_burst(1'b0, 16'h0005, 1, nk);
      chk("R5 page from long window used in short mode", int'(la[base % 64]), 16'h7E05);

      // R2: repeated start mid-write
      base = wr_n;
      b_start();
      tx_byte(8'hB6, a);
      tx_byte(8'h40, a);
      b_start();
      tx_byte(8'hB6, a);
      tx_byte(8'h41, a);
      tx_byte(8'h99, a);
      b_stop();
      chk("R2 restart count", wr_n - base, 1);
      chk("R2 restart address", int'(la[base % 64]), 16'h7E41);
      qwait();
      chk("R2 bus released after stop", int'(sda_line), 1);

      // random traffic
      for (int it = 0; it < 24; it++) begin
         logic wm;
         int n;
         logic [15:0] off;
         wm = 1'($urandom % 2);
         wide = wm;
         n = 1 + int'($urandom % 4);
         off = wm ? 16'($urandom % 32'hFFF0) : 16'($urandom % 32'hF8);
         if ($urandom % 2 == 0) begin
            for (int i = 0; i < n; i++) dbuf[i] = 8'($urandom);
            base = wr_n;
            wr_burst(wm, off, n, nk);
            chk("R7 random acks", nk, 0);
            chk("R7 random count", wr_n - base, n);
            for (int i = 0; i < n; i++) begin
               chk("R8 random address", int'(la[(base + i) % 64]), int'(exp_addr(wm, pg1, off + 16'(i))));
               chk("R7 random data", int'(ld[(base + i) % 64]), int'(dbuf[i]));
            end
         end else begin
            send_ptr(wm, off, nk);
            rd_burst(n, nk);
            b_stop();
            for (int i = 0; i < n; i++)
               chk("R9 random read", int'(rbuf[i]), int'(rdf(exp_addr(wm, pg1, off + 16'(i)))));
         end
      end

      chk("R12 drive steady while SCL high", oe_hi_chg, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule